// File: doc/BRIEF.md
# Byte FIFO with Water-Level Alerts

This block is a byte-wide first-in first-out store, 64 entries deep by default, that sits behind a host register interface and is shared with an internal protocol engine. The host pushes bytes with a strobe and pops them with another strobe through one data port. The engine has its own push and pop port. Whenever the engine is active, or holds ownership of the store, the engine wins and the host cannot write.

A level register reports how many bytes are held. If a write to that register carries its top bit set, the store is emptied at once. A programmable water level drives two alert flags, one for nearly empty and one for nearly full. A rising edge on either alert latches an interrupt-request bit, which stays set until the host clears it. Two sticky error bits record problems: a push into a full store, and a host write made while the engine owns the store.

Top module: `byte_fifo_wm`

## Requirements
- R1: Bytes leave in the order they entered. After a performed pop, the popped byte appears on the popping port's read-data output in the next cycle. Read data holds between pops.
- R2: `level_rd` reads the stored count in bits 6:0, with a range of 0 to 64. Bit 7 always reads 0.
- R3: A push while 64 bytes are stored is discarded, even if a pop happens in the same cycle. The push sets `ovf_err`, which stays at 1 until `err_clr[0]` is pulsed.
- R4: A pop from an empty store returns 0x00 on that port's read data. The count stays at 0 and no error bit is set.
- R5: A level-register write with `lvl_wr_flush`=1 makes the count 0 in the next cycle. Every push and pop in that cycle is dropped and raises no error. A level-register write with `lvl_wr_flush`=0 changes nothing.
- R6: `lo_alert` is 1 exactly when count <= water level.
- R7: `hi_alert` is 1 exactly when (64 - count) <= water level.
- R8: A 0-to-1 change of `lo_alert` sets `lo_irq`, and a 0-to-1 change of `hi_alert` sets `hi_irq`. Each bit is set one cycle after its alert rises. Each bit stays set until the matching bit of `irq_clr` is pulsed (bit 0 clears `lo_irq`, bit 1 clears `hi_irq`). If a set and a clear happen in the same cycle, the set wins.
- R9: In a cycle where the engine pushes or pops, the engine's access is performed. In any cycle where the engine pushes, pops or has `eng_own` high, the host's access is not performed. In those cycles a host push is discarded and sets `wr_err`, and a host pop leaves `host_rdata` unchanged.
- R10: `wr_err` stays at 1 until `err_clr[1]` is pulsed. `ovf_err` is cleared only by `err_clr[0]`. If an error is raised in the same cycle as its clear, the error wins.
- R11: After reset the count is 0 and the water level is 8. `lo_alert` is 1, `hi_alert` is 0, and both interrupt bits, both error bits and both read-data outputs are 0.
- R12: A write with `wl_wr` loads `wl_wdata` into the water level. The alerts use the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_push | input | 1 | Host push strobe |
| host_pop | input | 1 | Host pop strobe |
| host_wdata | input | 8 | Host byte to push |
| host_rdata | output | 8 | Last byte popped by the host |
| eng_push | input | 1 | Engine push strobe |
| eng_pop | input | 1 | Engine pop strobe |
| eng_wdata | input | 8 | Engine byte to push |
| eng_rdata | output | 8 | Last byte popped by the engine |
| eng_own | input | 1 | Engine holds ownership; host writes are refused |
| lvl_wr | input | 1 | Host write to the level register |
| lvl_wr_flush | input | 1 | Top bit of that write; 1 empties the store |
| level_rd | output | 8 | Level register read value |
| wl_wr | input | 1 | Water level write strobe |
| wl_wdata | input | 6 | New water level |
| lo_alert | output | 1 | Nearly-empty alert |
| hi_alert | output | 1 | Nearly-full alert |
| irq_clr | input | 2 | Interrupt clear pulses (bit 0 low, bit 1 high) |
| lo_irq | output | 1 | Latched nearly-empty interrupt request |
| hi_irq | output | 1 | Latched nearly-full interrupt request |
| err_clr | input | 2 | Error clear pulses (bit 0 overflow, bit 1 write error) |
| ovf_err | output | 1 | Sticky overflow error |
| wr_err | output | 1 | Sticky write-timing error |

## Verification
A wrong count or pointer shows on `level_rd` and on both alert flags in the cycle after the faulty update. A wrong pointer or a wrong memory write shows on the read-data outputs at the next pop that reaches the affected slot, which can be up to 64 pops later. A fault in arbitration or in the sticky error bits shows in `wr_err` or `ovf_err` one cycle after the offending access, and it persists because the bits are sticky. A missed interrupt edge stays visible as a missing request bit until the next clear.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  localparam int unsigned BFIFO_DW = 8;

  typedef struct packed {
    logic                push;
    logic                pop;
    logic [BFIFO_DW-1:0] data;
  } bfifo_req_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HOST = 2'd1,
    SRC_ENG  = 2'd2
  } bfifo_src_t;
endpackage

// File: rtl/bfifo_arb.sv
module bfifo_arb
  import bfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bfifo_req_t host_req,
  input  bfifo_req_t eng_req,
  input  logic       eng_own,
  input  logic       flush,
  input  logic       ovf_set,
  input  logic [1:0] err_clr,
  output bfifo_req_t sel_req,
  output bfifo_src_t sel_src,
  output logic       ovf_err,
  output logic       wr_err
);
  logic eng_act;
  logic wr_set;
  logic ovf_q, ovf_d, ovf_en;
  logic wre_q, wre_d, wre_en;

  // port selection: flush drops everything, engine beats host
  always_comb begin
    eng_act = eng_req.push | eng_req.pop;
    sel_req = '0;
    sel_src = SRC_NONE;
    wr_set  = 1'b0;
    if (flush) begin
      sel_req = '0;
    end else if (eng_act) begin
      sel_req = eng_req;
      sel_src = SRC_ENG;
      wr_set  = host_req.push;
    end else if (eng_own) begin
      wr_set  = host_req.push;
    end else if (host_req.push | host_req.pop) begin
      sel_req = host_req;
      sel_src = SRC_HOST;
    end
  end

  // sticky error bits, raise beats clear
  always_comb begin
    ovf_en = ovf_set | err_clr[0];
    ovf_d  = ovf_set;
    wre_en = wr_set | err_clr[1];
    wre_d  = wr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      wre_q <= 1'b0;
    end else begin
      if (ovf_en) ovf_q <= ovf_d;
      if (wre_en) wre_q <= wre_d;
    end
  end

  assign ovf_err = ovf_q;
  assign wr_err  = wre_q;
endmodule

// File: rtl/bfifo_store.sv
module bfifo_store
  import bfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  bfifo_req_t          req,
  input  bfifo_src_t          src,
  output logic [CW-1:0]       count,
  output logic [BFIFO_DW-1:0] host_rdata,
  output logic [BFIFO_DW-1:0] eng_rdata,
  output logic                ovf_set
);
  logic [BFIFO_DW-1:0] mem_q [DEPTH];
  logic [AW-1:0]       wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]       rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [BFIFO_DW-1:0] hrd_q, erd_q, pop_byte;
  logic                full, empty, do_push, do_pop;
  logic                cnt_en, hrd_en, erd_en;

  always_comb begin
    full     = (cnt_q == CW'(DEPTH));
    empty    = (cnt_q == '0);
    do_push  = req.push & ~full;
    do_pop   = req.pop & ~empty;
    ovf_set  = req.push & full;
    pop_byte = empty ? '0 : mem_q[rd_ptr_q];
    cnt_en   = flush | do_push | do_pop;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      wr_ptr_d = do_push ? wr_ptr_q + AW'(1) : wr_ptr_q;
      rd_ptr_d = do_pop  ? rd_ptr_q + AW'(1) : rd_ptr_q;
      cnt_d    = cnt_q + CW'(do_push) - CW'(do_pop);
    end
    hrd_en = req.pop & (src == SRC_HOST);
    erd_en = req.pop & (src == SRC_ENG);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= req.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      hrd_q    <= '0;
      erd_q    <= '0;
    end else begin
      if (cnt_en) begin
        wr_ptr_q <= wr_ptr_d;
        rd_ptr_q <= rd_ptr_d;
        cnt_q    <= cnt_d;
      end
      if (hrd_en) hrd_q <= pop_byte;
      if (erd_en) erd_q <= pop_byte;
    end
  end

  assign count      = cnt_q;
  assign host_rdata = hrd_q;
  assign eng_rdata  = erd_q;
endmodule

// File: rtl/bfifo_alert.sv
module bfifo_alert #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned RST_WL = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned NALRT = 2,
  localparam logic [NALRT-1:0] RST_ALRT =
    {(DEPTH <= RST_WL) ? 1'b1 : 1'b0, 1'b1}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    count,
  input  logic             wl_wr,
  input  logic [AW-1:0]    wl_wdata,
  input  logic [NALRT-1:0] irq_clr,
  output logic [NALRT-1:0] alert,
  output logic [NALRT-1:0] irq
);
  logic [AW-1:0] wl_q;
  logic [CW-1:0] room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wl_q <= AW'(RST_WL);
    else if (wl_wr) wl_q <= wl_wdata;
  end

  always_comb begin
    room     = CW'(DEPTH) - count;
    alert[0] = count <= CW'(wl_q);
    alert[1] = room  <= CW'(wl_q);
  end

  for (genvar g = 0; g < NALRT; g++) begin : g_irq
    logic prev_q, irq_q, irq_d, irq_en, rise;
    always_comb begin
      rise   = alert[g] & ~prev_q;
      irq_en = rise | irq_clr[g];
      irq_d  = rise;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= RST_ALRT[g];
        irq_q  <= 1'b0;
      end else begin
        prev_q <= alert[g];
        if (irq_en) irq_q <= irq_d;
      end
    end
    assign irq[g] = irq_q;
  end
endmodule

// File: rtl/byte_fifo_wm.sv
module byte_fifo_wm
  import bfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned RST_WL = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_push,
  input  logic                host_pop,
  input  logic [BFIFO_DW-1:0] host_wdata,
  output logic [BFIFO_DW-1:0] host_rdata,
  input  logic                eng_push,
  input  logic                eng_pop,
  input  logic [BFIFO_DW-1:0] eng_wdata,
  output logic [BFIFO_DW-1:0] eng_rdata,
  input  logic                eng_own,
  input  logic                lvl_wr,
  input  logic                lvl_wr_flush,
  output logic [CW:0]         level_rd,
  input  logic                wl_wr,
  input  logic [AW-1:0]       wl_wdata,
  output logic                lo_alert,
  output logic                hi_alert,
  input  logic [1:0]          irq_clr,
  output logic                lo_irq,
  output logic                hi_irq,
  input  logic [1:0]          err_clr,
  output logic                ovf_err,
  output logic                wr_err
);
  bfifo_req_t    host_req, eng_req, sel_req;
  bfifo_src_t    sel_src;
  logic          flush, ovf_set;
  logic [CW-1:0] count;
  logic [1:0]    alert, irq;

  assign flush    = lvl_wr & lvl_wr_flush;
  assign host_req = '{push: host_push, pop: host_pop, data: host_wdata};
  assign eng_req  = '{push: eng_push,  pop: eng_pop,  data: eng_wdata};

  bfifo_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_req (host_req),
    .eng_req  (eng_req),
    .eng_own  (eng_own),
    .flush    (flush),
    .ovf_set  (ovf_set),
    .err_clr  (err_clr),
    .sel_req  (sel_req),
    .sel_src  (sel_src),
    .ovf_err  (ovf_err),
    .wr_err   (wr_err)
  );

  bfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req        (sel_req),
    .src        (sel_src),
    .count      (count),
    .host_rdata (host_rdata),
    .eng_rdata  (eng_rdata),
    .ovf_set    (ovf_set)
  );

  bfifo_alert #(.DEPTH(DEPTH), .RST_WL(RST_WL)) u_alert (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .wl_wr    (wl_wr),
    .wl_wdata (wl_wdata),
    .irq_clr  (irq_clr),
    .alert    (alert),
    .irq      (irq)
  );

  assign level_rd = {1'b0, count};
  assign lo_alert = alert[0];
  assign hi_alert = alert[1];
  assign lo_irq   = irq[0];
  assign hi_irq   = irq[1];
endmodule

// File: rtl/byte_fifo_wm_chk.sv
module byte_fifo_wm_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_push,
  input logic        host_pop,
  input logic        eng_push,
  input logic        eng_pop,
  input logic        eng_own,
  input logic        lvl_wr,
  input logic        lvl_wr_flush,
  input logic [1:0]  err_clr,
  input logic [CW:0] level_rd,
  input logic        lo_alert,
  input logic        lo_irq,
  input logic        ovf_err,
  input logic        wr_err,
  input logic [7:0]  host_rdata
);
  logic flush_c, eng_busy;
  assign flush_c  = lvl_wr & lvl_wr_flush;
  assign eng_busy = eng_push | eng_pop | eng_own;

  assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_rd[CW] == 1'b0) && (level_rd <= (CW+1)'(DEPTH)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_rd == (CW+1)'(DEPTH) && eng_push && !flush_c) |=> ovf_err);

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_rd == '0 && host_pop && !host_push && !eng_busy && !flush_c)
      |=> (host_rdata == 8'h00 && level_rd == '0));

  assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_c |=> (level_rd == '0));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_alert) |=> lo_irq);

  assert_host_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && eng_busy && !flush_c) |=> wr_err);

  assert_wr_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !err_clr[1]) |=> wr_err);
endmodule

bind byte_fifo_wm byte_fifo_wm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_push    (host_push),
  .host_pop     (host_pop),
  .eng_push     (eng_push),
  .eng_pop      (eng_pop),
  .eng_own      (eng_own),
  .lvl_wr       (lvl_wr),
  .lvl_wr_flush (lvl_wr_flush),
  .err_clr      (err_clr),
  .level_rd     (level_rd),
  .lo_alert     (lo_alert),
  .lo_irq       (lo_irq),
  .ovf_err      (ovf_err),
  .wr_err       (wr_err),
  .host_rdata   (host_rdata)
);

// File: tb/tb_byte_fifo_wm.sv
`timescale 1ns/1ps
module tb_byte_fifo_wm;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_push, host_pop, eng_push, eng_pop, eng_own;
  logic [7:0] host_wdata, eng_wdata, host_rdata, eng_rdata, level_rd;
  logic       lvl_wr, lvl_wr_flush, wl_wr;
  logic [5:0] wl_wdata;
  logic       lo_alert, hi_alert, lo_irq, hi_irq, ovf_err, wr_err;
  logic [1:0] irq_clr, err_clr;

  int checks = 0;
  int fails  = 0;

  // reference model state
  byte unsigned q[$];
  int           m_wl;
  bit           m_lo_p, m_hi_p, m_lo_irq, m_hi_irq, m_ovf, m_wr;
  byte unsigned m_hrd, m_erd;

  always #2 clk = ~clk;

  byte_fifo_wm dut (
    .clk(clk), .rst_n(rst_n),
    .host_push(host_push), .host_pop(host_pop), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .eng_push(eng_push), .eng_pop(eng_pop), .eng_wdata(eng_wdata),
    .eng_rdata(eng_rdata), .eng_own(eng_own),
    .lvl_wr(lvl_wr), .lvl_wr_flush(lvl_wr_flush), .level_rd(level_rd),
    .wl_wr(wl_wr), .wl_wdata(wl_wdata),
    .lo_alert(lo_alert), .hi_alert(hi_alert),
    .irq_clr(irq_clr), .lo_irq(lo_irq), .hi_irq(hi_irq),
    .err_clr(err_clr), .ovf_err(ovf_err), .wr_err(wr_err)
  );

  function automatic bit exp_lo(int cnt, int wl); return cnt <= wl; endfunction
  function automatic bit exp_hi(int cnt, int wl); return (64 - cnt) <= wl; endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    host_push = 0; host_pop = 0; host_wdata = 0;
    eng_push = 0; eng_pop = 0; eng_wdata = 0; eng_own = 0;
    lvl_wr = 0; lvl_wr_flush = 0; wl_wr = 0; wl_wdata = 0;
    irq_clr = 0; err_clr = 0;
  endtask

  task automatic model_access(bit push, bit pop, byte unsigned d,
                              ref byte unsigned rd, output bit ovf);
    bit e = (q.size() == 0);
    bit f = (q.size() == 64);
    ovf = 0;
    if (pop) rd = e ? 8'h00 : q.pop_front();
    if (push) begin
      if (f) ovf = 1;
      else   q.push_back(d);
    end
  endtask

  task automatic model_step();
    bit lo_a = exp_lo(q.size(), m_wl);
    bit hi_a = exp_hi(q.size(), m_wl);
    bit ovf_s = 0, wr_s = 0;
    m_lo_irq = (lo_a & !m_lo_p) | (m_lo_irq & !irq_clr[0]);
    m_hi_irq = (hi_a & !m_hi_p) | (m_hi_irq & !irq_clr[1]);
    m_lo_p = lo_a; m_hi_p = hi_a;
    if (lvl_wr && lvl_wr_flush) q.delete();
    else if (eng_push || eng_pop) begin
      wr_s = host_push;
      model_access(eng_push, eng_pop, eng_wdata, m_erd, ovf_s);
    end else if (eng_own) wr_s = host_push;
    else if (host_push || host_pop)
      model_access(host_push, host_pop, host_wdata, m_hrd, ovf_s);
    m_ovf = ovf_s | (m_ovf & !err_clr[0]);
    m_wr  = wr_s  | (m_wr  & !err_clr[1]);
    if (wl_wr) m_wl = wl_wdata;
  endtask

  task automatic compare_all();
    chk("R2", "level", level_rd, q.size());
    chk("R6", "lo_alert", lo_alert, exp_lo(q.size(), m_wl));
    chk("R7", "hi_alert", hi_alert, exp_hi(q.size(), m_wl));
    chk("R8", "lo_irq", lo_irq, m_lo_irq);
    chk("R8", "hi_irq", hi_irq, m_hi_irq);
    chk("R3", "ovf_err", ovf_err, m_ovf);
    chk("R9 R10", "wr_err", wr_err, m_wr);
    chk("R1", "host_rdata", host_rdata, m_hrd);
    chk("R1", "eng_rdata", eng_rdata, m_erd);
  endtask

  // inputs are set at a falling edge before calling tick
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    idle();
    rst_n = 0;
    q.delete(); m_wl = 8; m_lo_p = 1; m_hi_p = 0;
    m_lo_irq = 0; m_hi_irq = 0; m_ovf = 0; m_wr = 0; m_hrd = 0; m_erd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "level", level_rd, 0);
    chk("R11", "lo_alert", lo_alert, 1);
    chk("R11", "hi_alert", hi_alert, 0);
    chk("R11", "irqs", {lo_irq, hi_irq}, 0);
    chk("R11", "errors", {ovf_err, wr_err}, 0);
    chk("R11", "rdata", {host_rdata, eng_rdata}, 0);

    // fill to 64 then one more push: R3 overflow
    for (int i = 0; i < 64; i++) begin
      host_push = 1; host_wdata = 8'(i * 3 + 1); tick();
    end
    chk("R7", "hi_irq after fill", hi_irq, 1);
    host_push = 1; host_wdata = 8'hEE; host_pop = 1; tick();
    chk("R3", "level after full push+pop", level_rd, 63);
    chk("R3", "ovf sticky", ovf_err, 1);
    tick();
    chk("R3", "ovf holds", ovf_err, 1);
    err_clr = 2'b01; tick();
    chk("R10", "ovf cleared", ovf_err, 0);

    // drain and check order R1, then R4 empty pop
    while (q.size() > 0) begin host_pop = 1; tick(); end
    irq_clr = 2'b11; tick();
    host_pop = 1; tick();
    chk("R4", "empty pop data", host_rdata, 0);
    chk("R4", "empty pop level", level_rd, 0);
    chk("R4", "empty pop errors", {ovf_err, wr_err}, 0);

    // R9: engine ownership and same-cycle collision
    eng_own = 1; host_push = 1; host_wdata = 8'h55; tick();
    chk("R9", "blocked push level", level_rd, 0);
    chk("R9", "wr_err set", wr_err, 1);
    eng_push = 1; eng_wdata = 8'hA5; host_push = 1; host_wdata = 8'h5A; tick();
    chk("R9", "engine wins", level_rd, 1);
    host_pop = 1; eng_pop = 1; tick();
    chk("R9", "engine popped", eng_rdata, 8'hA5);
    chk("R9", "host rdata held", host_rdata, 0);
    err_clr = 2'b10; host_push = 1; eng_own = 1; tick();
    chk("R10", "set beats clear", wr_err, 1);
    err_clr = 2'b10; tick();
    chk("R10", "wr_err cleared", wr_err, 0);

    // R5 flush, and write without the flush bit
    for (int i = 0; i < 5; i++) begin host_push = 1; host_wdata = 8'(i); tick(); end
    lvl_wr = 1; lvl_wr_flush = 0; tick();
    chk("R5", "no-flush write", level_rd, 5);
    lvl_wr = 1; lvl_wr_flush = 1; host_push = 1; eng_own = 1; tick();
    chk("R5", "flushed", level_rd, 0);
    chk("R5", "no error on flush", wr_err, 0);

    // R12 water level change
    for (int i = 0; i < 20; i++) begin host_push = 1; host_wdata = 8'(i); tick(); end
    chk("R12", "lo before", lo_alert, 0);
    wl_wr = 1; wl_wdata = 6'd20; tick();
    chk("R12", "lo after wl=20", lo_alert, 1);
    wl_wr = 1; wl_wdata = 6'd44; tick();
    chk("R12", "hi after wl=44", hi_alert, 1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      host_push  = ($urandom_range(0, 99) < 55);
      host_pop   = ($urandom_range(0, 99) < 40);
      host_wdata = 8'($urandom);
      eng_push   = ($urandom_range(0, 99) < 8);
      eng_pop    = ($urandom_range(0, 99) < 8);
      eng_wdata  = 8'($urandom);
      eng_own    = ($urandom_range(0, 99) < 6);
      lvl_wr     = (r < 3);
      lvl_wr_flush = (r < 1) || ($urandom_range(0, 1) == 1 && r < 2);
      wl_wr      = ($urandom_range(0, 99) < 2);
      wl_wdata   = 6'($urandom);
      irq_clr    = ($urandom_range(0, 99) < 10) ? 2'($urandom) : 2'b00;
      err_clr    = ($urandom_range(0, 99) < 10) ? 2'($urandom) : 2'b00;
      tick();
    end
    finish_run();
  end
endmodule